// File: doc/BRIEF.md
# Reference Clock Loss Monitor

This block watches a slow external reference clock and decides, window by window, whether that clock is still running fast enough. Its timebase is the clock produced by the on-chip frequency-locked loop, called the monitor clock here. The reference is brought into the monitor-clock domain and its rising edges are counted over a fixed window of monitor-clock cycles. If a window holds fewer edges than the minimum set for the selected frequency range, the block raises a reset request for a fixed number of cycles. It also sets a sticky fault flag, which tells software after the restart why the chip was reset.

The monitor runs only when software has enabled it, when the loop is producing a usable clock, and when the clock generator is in one of its four loop-on modes. In the two low-power bypass modes the loop is off, so the monitor stays idle whatever the enable says. The first window after the monitor starts, and the first window after a range change, is always discarded. This keeps a partial count from raising a false fault. The fault flag is kept out of the system reset that it causes. Only a power-on reset or a write of one from software clears it.

Top module: `refclk_loss_monitor`

## Requirements
- R1: Monitoring is active only while `mon_enable`=1, `loop_ready`=1 and `mode` is a loop-on code: 0 (loop engaged, internal reference), 1 (loop engaged, external reference), 2 (loop bypassed, internal reference) or 3 (loop bypassed, external reference). When it is not active, no reset request is raised.
- R2: Mode codes 4 and 5 (low-power bypass, internal or external) and the unused codes 6 and 7 never produce a reset request, even with `mon_enable`=1 and a stopped reference.
- R3: A window is `WIN_CYCLES` monitor-clock cycles long. A loss is declared when the window counts fewer than `MIN_EDGES_LO` rising reference edges with `range_hi`=0, or fewer than `MIN_EDGES_HI` with `range_hi`=1. A loss raises `reset_req`.
- R4: A reference whose edge count per window is at or above the selected minimum never raises `reset_req`.
- R5: The first window after the monitor becomes active is discarded, and so is the first window after `range_hi` changes. With a stopped reference, `reset_req` first reads 1 after 2*`WIN_CYCLES`+1 monitor-clock edges counted from activation, or after 2*`WIN_CYCLES`+2 edges counted from a range change.
- R6: Each reset request holds `reset_req` at 1 for exactly `HOLD_CYCLES` monitor-clock cycles, then releases it.
- R7: `cause_flag` is set on the same edge that raises `reset_req`, and it keeps its value through a system reset (`rst_n`=0).
- R8: `cause_flag` is cleared by a power-on reset (`por_n`=0) or by `cause_clr`=1 for one cycle. While `cause_clr`=0 the flag does not change.
- R9: While reset is applied, `reset_req` and `cause_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mon_clk | input | 1 | Monitor clock from the loop; timebase for all logic |
| por_n | input | 1 | Power-on reset, synchronous, active low; clears everything |
| rst_n | input | 1 | System reset, synchronous, active low; leaves `cause_flag` alone |
| ref_clk | input | 1 | External reference clock under watch, asynchronous |
| mon_enable | input | 1 | Software enable for the monitor |
| mode | input | 3 | Clock generator mode code (see R1, R2) |
| range_hi | input | 1 | Frequency range select: 0 low, 1 high threshold |
| loop_ready | input | 1 | Loop output is stable and usable as a timebase |
| cause_clr | input | 1 | Software write-one pulse that clears `cause_flag` |
| reset_req | output | 1 | Reset request to the reset sequencer |
| cause_flag | output | 1 | Sticky clock-loss reset cause |

## Verification
Every cycle, the assertions check the length of each reset request. They also check that the flag is already set when a request begins, that the flag never falls without a clear, and that no request begins unless the monitor was active when the window closed. Only the bench's scenarios show the frequency decision itself. These cover the two ranges at several reference rates, the idle behaviour in the low-power and unused modes, the exact start-up and range-change latency, and the flag surviving a system reset.

// File: rtl/refmon_pkg.sv
// Package: shared mode codes and helpers for the reference clock loss monitor.
// Assumes a 3-bit clock generator mode code; codes 6 and 7 are unused.
package refmon_pkg;

    localparam int MODE_W = 3;

    localparam logic [MODE_W-1:0] MODE_ENG_INT    = 3'd0;
    localparam logic [MODE_W-1:0] MODE_ENG_EXT    = 3'd1;
    localparam logic [MODE_W-1:0] MODE_BYP_INT    = 3'd2;
    localparam logic [MODE_W-1:0] MODE_BYP_EXT    = 3'd3;
    localparam logic [MODE_W-1:0] MODE_BYP_INT_LP = 3'd4;
    localparam logic [MODE_W-1:0] MODE_BYP_EXT_LP = 3'd5;

    // True for the modes in which the loop runs and can serve as a timebase.
    function automatic logic mode_loop_on(input logic [MODE_W-1:0] m);
        return (m == MODE_ENG_INT) || (m == MODE_ENG_EXT) ||
               (m == MODE_BYP_INT) || (m == MODE_BYP_EXT);
    endfunction

endpackage

// File: rtl/refmon_sync_edge.sv
// Module: brings the asynchronous reference into the monitor domain through
// a flop chain and flags each rising edge for one monitor cycle.
// Assumes the reference is slower than half the monitor clock.
module refmon_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    localparam int CHAIN_W = STAGES + 1;

    logic [CHAIN_W-1:0] chain;

    // Shift the sampled reference through the chain; the last stage is history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain[0] <= async_in;
            for (int i = 1; i < CHAIN_W; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    // Rising edge: the synchronized level is high and the history is low.
    assign rise = chain[STAGES-1] & ~chain[STAGES];

endmodule

// File: rtl/refmon_window.sv
// Module: counts reference edges over fixed windows of monitor cycles and
// pulses loss for one cycle when a window comes up short.
// Assumes rise is already synchronous; a restart discards the next window.
module refmon_window #(
    parameter int WIN_CYCLES   = 64,
    parameter int MIN_EDGES_LO = 3,
    parameter int MIN_EDGES_HI = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic range_hi,
    input  logic rise,
    output logic loss
);
    localparam int WIN_W  = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1;
    localparam int EDGE_W = $clog2(WIN_CYCLES + 1);
    localparam logic [WIN_W-1:0]  WIN_LAST = WIN_W'(WIN_CYCLES - 1);
    localparam logic [EDGE_W-1:0] THR_LO   = EDGE_W'(MIN_EDGES_LO);
    localparam logic [EDGE_W-1:0] THR_HI   = EDGE_W'(MIN_EDGES_HI);

    logic [WIN_W-1:0]  win_cnt;
    logic [EDGE_W-1:0] edge_cnt;
    logic [EDGE_W-1:0] edge_total;
    logic [EDGE_W-1:0] threshold;
    logic              discard;
    logic              range_q;
    logic              restart;
    logic              win_end;
    logic              short_win;

    // Decode the window end and the restart conditions.
    always_comb begin
        restart    = !active || (range_hi != range_q);
        win_end    = (win_cnt == WIN_LAST);
        edge_total = edge_cnt + EDGE_W'(rise);
        threshold  = range_hi ? THR_HI : THR_LO;
        short_win  = (edge_total < threshold);
    end

    // Advance the window, accumulate edges and judge each finished window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_cnt  <= '0;
            edge_cnt <= '0;
            discard  <= 1'b1;
            range_q  <= 1'b0;
            loss     <= 1'b0;
        end else begin
            range_q <= range_hi;
            loss    <= 1'b0;
            if (restart) begin
                win_cnt  <= '0;
                edge_cnt <= '0;
                discard  <= 1'b1;
            end else if (win_end) begin
                win_cnt  <= '0;
                edge_cnt <= '0;
                discard  <= 1'b0;
                loss     <= !discard && short_win;
            end else begin
                win_cnt  <= win_cnt + 1'b1;
                edge_cnt <= edge_total;
            end
        end
    end

endmodule

// File: rtl/refmon_hold.sv
// Module: stretches a one-cycle loss pulse into a reset request of fixed
// length. Triggers that arrive while a request is running are ignored.
module refmon_hold #(
    parameter int HOLD_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic req
);
    localparam int HOLD_W = $clog2(HOLD_CYCLES + 1);

    logic [HOLD_W-1:0] remain;

    // Load the hold length on a trigger, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end else if (trig) begin
            remain <= HOLD_W'(HOLD_CYCLES);
        end
    end

    assign req = (remain != '0);

endmodule

// File: rtl/refmon_cause.sv
// Module: sticky reset-cause flag. Only the power-on reset clears it; the
// system reset merely blocks new sets. A set wins over a clear.
module refmon_cause (
    input  logic clk,
    input  logic por_n,
    input  logic sys_ok,
    input  logic set,
    input  logic clr,
    output logic flag
);
    // Set on a loss, clear on a write of one, survive the system reset.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            flag <= 1'b0;
        end else if (sys_ok && set) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end

endmodule

// File: rtl/refclk_loss_monitor.sv
// Module: top of the reference clock loss monitor. It gates the measurement
// on enable, mode and loop readiness, and combines the window judge, the
// request stretcher and the sticky cause flag.
// Assumes mon_clk is valid whenever loop_ready is 1; both resets are synchronous.
module refclk_loss_monitor
    import refmon_pkg::*;
#(
    parameter int WIN_CYCLES   = 64,
    parameter int MIN_EDGES_LO = 3,
    parameter int MIN_EDGES_HI = 12,
    parameter int HOLD_CYCLES  = 8,
    parameter int SYNC_STAGES  = 2
) (
    input  logic              mon_clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              ref_clk,
    input  logic              mon_enable,
    input  logic [MODE_W-1:0] mode,
    input  logic              range_hi,
    input  logic              loop_ready,
    input  logic              cause_clr,
    output logic              reset_req,
    output logic              cause_flag
);
    logic sys_ok;
    logic active;
    logic ref_rise;
    logic loss;

    // Combined reset for the measurement path and the run condition.
    always_comb begin
        sys_ok = rst_n && por_n;
        active = mon_enable && loop_ready && mode_loop_on(mode);
    end

    refmon_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (mon_clk),
        .rst_n    (sys_ok),
        .async_in (ref_clk),
        .rise     (ref_rise)
    );

    refmon_window #(
        .WIN_CYCLES   (WIN_CYCLES),
        .MIN_EDGES_LO (MIN_EDGES_LO),
        .MIN_EDGES_HI (MIN_EDGES_HI)
    ) u_window (
        .clk      (mon_clk),
        .rst_n    (sys_ok),
        .active   (active),
        .range_hi (range_hi),
        .rise     (ref_rise),
        .loss     (loss)
    );

    refmon_hold #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
        .clk   (mon_clk),
        .rst_n (sys_ok),
        .trig  (loss),
        .req   (reset_req)
    );

    refmon_cause u_cause (
        .clk    (mon_clk),
        .por_n  (por_n),
        .sys_ok (sys_ok),
        .set    (loss),
        .clr    (cause_clr),
        .flag   (cause_flag)
    );

endmodule

// File: rtl/refmon_chk.sv
// Module: property checker for the reference clock loss monitor, bound to
// the top. It watches the ports only.
module refmon_chk
    import refmon_pkg::*;
#(
    parameter int HOLD_CYCLES = 8
) (
    input logic              mon_clk,
    input logic              por_n,
    input logic              rst_n,
    input logic              mon_enable,
    input logic [MODE_W-1:0] mode,
    input logic              loop_ready,
    input logic              cause_clr,
    input logic              reset_req,
    input logic              cause_flag
);
    int  run;
    logic act;

    assign act = mon_enable && loop_ready && mode_loop_on(mode);

    // Count consecutive cycles with the request high.
    always_ff @(posedge mon_clk) begin
        if (!por_n || !rst_n) run <= 0;
        else if (reset_req)   run <= run + 1;
        else                  run <= 0;
    end

    // R6
    req_len_chk: assert property (@(posedge mon_clk) disable iff (!por_n || !rst_n)
        ($fell(reset_req) && $past(rst_n && por_n)) |-> (run == HOLD_CYCLES));

    // R6
    req_bound_chk: assert property (@(posedge mon_clk) disable iff (!por_n || !rst_n)
        reset_req |-> (run < HOLD_CYCLES));

    // R7
    flag_with_req_chk: assert property (@(posedge mon_clk) disable iff (!por_n || !rst_n)
        $rose(reset_req) |-> cause_flag);

    // R8
    flag_sticky_chk: assert property (@(posedge mon_clk) disable iff (!por_n)
        (cause_flag && !cause_clr) |=> cause_flag);

    // R1
    req_needs_active_chk: assert property (@(posedge mon_clk) disable iff (!por_n || !rst_n)
        $rose(reset_req) |-> $past(act, 2));

endmodule

bind refclk_loss_monitor refmon_chk #(.HOLD_CYCLES(HOLD_CYCLES)) u_chk (
    .mon_clk    (mon_clk),
    .por_n      (por_n),
    .rst_n      (rst_n),
    .mon_enable (mon_enable),
    .mode       (mode),
    .loop_ready (loop_ready),
    .cause_clr  (cause_clr),
    .reset_req  (reset_req),
    .cause_flag (cause_flag)
);

// File: tb/refclk_loss_monitor_test.sv
module refclk_loss_monitor_test;
    localparam int CLK_PERIOD = 10;
    localparam int WIN  = 64;
    localparam int HOLD = 8;

    typedef struct packed {
        logic [2:0] mode;
        logic       en;
        logic       rng;
        logic       rdy;
        logic [7:0] half;   // reference half period in monitor cycles, 0 = stopped
        logic       exp;    // reset request expected
        logic [3:0] req;    // requirement number
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VECS [NVEC] = '{
        '{3'd0, 1'b1, 1'b0, 1'b1, 8'd2,  1'b0, 4'd4},  // R4 fast, low range
        '{3'd1, 1'b1, 1'b1, 1'b1, 8'd2,  1'b0, 4'd4},  // R4 fast, high range
        '{3'd2, 1'b1, 1'b0, 1'b1, 8'd0,  1'b1, 4'd3},  // R3 stopped
        '{3'd3, 1'b1, 1'b1, 1'b1, 8'd5,  1'b1, 4'd3},  // R3 medium below high min
        '{3'd0, 1'b1, 1'b0, 1'b1, 8'd5,  1'b0, 4'd4},  // R4 medium above low min
        '{3'd4, 1'b1, 1'b0, 1'b1, 8'd0,  1'b0, 4'd2},  // R2 low-power internal
        '{3'd5, 1'b1, 1'b0, 1'b1, 8'd0,  1'b0, 4'd2},  // R2 low-power external
        '{3'd0, 1'b0, 1'b0, 1'b1, 8'd0,  1'b0, 4'd1},  // R1 disabled
        '{3'd1, 1'b1, 1'b0, 1'b0, 8'd0,  1'b0, 4'd1},  // R1 loop not ready
        '{3'd6, 1'b1, 1'b0, 1'b1, 8'd0,  1'b0, 4'd2},  // R2 unused code
        '{3'd3, 1'b1, 1'b0, 1'b1, 8'd16, 1'b1, 4'd3},  // R3 slow, low range
        '{3'd0, 1'b1, 1'b1, 1'b1, 8'd16, 1'b1, 4'd3}   // R3 slow, high range
    };

    logic       clk = 1'b0;
    logic       por_n, rst_n, ref_clk, en, rng, rdy, clr;
    logic [2:0] mode;
    logic       reset_req, cause_flag;

    int  n_tests = 0;
    int  n_fail  = 0;
    int  half    = 0;
    int  ph      = 0;
    int  rose_cnt = 0;
    logic req_d  = 1'b0;
    logic cnt_clr = 1'b0;
    logic done   = 1'b0;

    refclk_loss_monitor #(
        .WIN_CYCLES(WIN), .MIN_EDGES_LO(3), .MIN_EDGES_HI(12),
        .HOLD_CYCLES(HOLD), .SYNC_STAGES(2)
    ) uut (
        .mon_clk(clk), .por_n(por_n), .rst_n(rst_n), .ref_clk(ref_clk),
        .mon_enable(en), .mode(mode), .range_hi(rng), .loop_ready(rdy),
        .cause_clr(clr), .reset_req(reset_req), .cause_flag(cause_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference generator, stepped on the falling monitor edge.
    initial ref_clk = 1'b0;
    always @(negedge clk) begin
        if (half == 0) begin
            ref_clk = 1'b0;
            ph = 0;
        end else if (ph + 1 >= half) begin
            ref_clk = ~ref_clk;
            ph = 0;
        end else begin
            ph = ph + 1;
        end
    end

    // Count request rising edges seen at falling-edge samples.
    always @(negedge clk) begin
        if (cnt_clr) rose_cnt = 0;
        else if (reset_req && !req_d) rose_cnt = rose_cnt + 1;
        req_d = reset_req;
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic full_reset();
        por_n = 1'b0; rst_n = 1'b0;
        cyc(3);
        por_n = 1'b1; rst_n = 1'b1;
    endtask

    initial begin
        por_n = 1'b0; rst_n = 1'b0; en = 1'b0; rng = 1'b0; rdy = 1'b0;
        clr = 1'b0; mode = 3'd0;
        cyc(4);
        // R9 outputs held low in reset
        chk("R9 req in reset", int'(reset_req), 0);
        chk("R9 flag in reset", int'(cause_flag), 0);
        por_n = 1'b1; rst_n = 1'b1;

        // Table walk (R1 R2 R3 R4)
        for (int v = 0; v < NVEC; v++) begin
            full_reset();
            mode = VECS[v].mode; en = VECS[v].en; rng = VECS[v].rng;
            rdy = VECS[v].rdy; half = int'(VECS[v].half);
            cnt_clr = 1'b1; cyc(1); cnt_clr = 1'b0;
            cyc(4*WIN + 20);
            chk($sformatf("R%0d vec%0d request seen", VECS[v].req, v),
                int'(rose_cnt > 0), int'(VECS[v].exp));
            chk($sformatf("R%0d vec%0d flag", VECS[v].req, v),
                int'(cause_flag), int'(VECS[v].exp));
            en = 1'b0;
        end

        // R5 start-up latency, R6 hold length, R7 flag behaviour
        full_reset();
        mode = 3'd0; rng = 1'b0; rdy = 1'b1; half = 0; en = 1'b0;
        cyc(5);
        en = 1'b1;
        cyc(2*WIN);
        chk("R5 no request before second window ends", int'(reset_req), 0);
        chk("R7 flag clear before request", int'(cause_flag), 0);
        cyc(1);
        chk("R5 request after second window", int'(reset_req), 1);
        chk("R7 flag set with request", int'(cause_flag), 1);
        begin
            int hi = 0;
            for (int k = 0; k < 4*HOLD && reset_req; k++) begin
                hi++;
                cyc(1);
            end
            chk("R6 request length", hi, HOLD);
        end
        en = 1'b0;
        rst_n = 1'b0; cyc(2); rst_n = 1'b1; cyc(1);
        chk("R7 flag survives system reset", int'(cause_flag), 1);
        chk("R9 request low after system reset", int'(reset_req), 0);
        cyc(10);
        chk("R8 flag holds without clear", int'(cause_flag), 1);
        clr = 1'b1; cyc(1); clr = 1'b0;
        chk("R8 write one clears flag", int'(cause_flag), 0);

        // R8 power-on reset clears a set flag
        en = 1'b1; cyc(2*WIN + 4); en = 1'b0;
        chk("R8 flag set again", int'(cause_flag), 1);
        full_reset(); cyc(1);
        chk("R8 power-on reset clears flag", int'(cause_flag), 0);

        // R5 range change discards one window
        mode = 3'd0; rng = 1'b0; rdy = 1'b1; half = 5; en = 1'b1;
        cnt_clr = 1'b1; cyc(1); cnt_clr = 1'b0;
        cyc(3*WIN);
        chk("R4 medium rate low range quiet", rose_cnt, 0);
        rng = 1'b1;
        cyc(2*WIN + 1);
        chk("R5 no request before range window", int'(reset_req), 0);
        cyc(1);
        chk("R5 request after range change", int'(reset_req), 1);
        en = 1'b0;
        cyc(HOLD + 2);

        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule